// File: doc/BRIEF.md
# Dual-Channel GPIO with Change Interrupt

This peripheral drives and samples up to two banks of general-purpose pins, each bank up to 32 bits wide. Every bank has an output data register and a direction register. A direction bit of 1 turns the pin's output driver off so the pin acts as an input. A direction bit of 0 drives the pin from the data register. Pin inputs are resynchronised into the block's clock domain. A read of a bank's data register returns the synchronised pin levels, not the stored output value.

Each bank owns one interrupt status bit. That bit is set whenever any implemented input bit of the bank changes level; there is no per-pin edge or polarity selection. Software acknowledges a pending bit by writing the value it just read back to the status register, because writing a 1 toggles a status bit. A per-bank enable register and a single global enable bit qualify the status bits onto one interrupt line. The bus is a single-cycle register port: the read data follows the address combinationally, and a write takes effect at the next rising clock edge.

The second bank is present only when the dual-bank parameter is set. Otherwise its registers and outputs stay at zero.

Top module: `gpio_dual_chg`

## Requirements
- R1: Byte offsets (with bus_addr[1:0] equal to 0) are: bank 1 data 0x000, bank 1 direction 0x004, bank 2 data 0x008, bank 2 direction 0x00C, global enable 0x11C, status 0x120, enable 0x128. Status and enable bit 0 belong to bank 1 and bit 1 to bank 2.
- R2: The output-enable pins are the inverse of the direction register, where 1 means input and 0 means driven. The output pins always show the data register. Both follow a write at the next rising edge.
- R3: After reset, the data and direction registers hold their per-bank reset parameters, masked to the bank width. The default direction reset value is all ones. Status, enable and global enable reset to 0.
- R4: A data-register read returns the pin inputs as sampled two rising edges earlier, through a two-flop synchronizer.
- R5: A level change on any implemented input bit of a bank sets that bank's status bit at the third rising edge after the pin changes.
- R6: A status write toggles every bit where the write data is 1 and leaves bits where it is 0. If a change is detected in the same cycle as a toggle, the bit ends up set.
- R7: irq_o is high exactly when global enable bit 31 is set and status AND enable is nonzero.
- R8: Register bits above a bank's width read as 0 and ignore writes. Unmapped or unaligned addresses read as 0, and writes to them change nothing.
- R9: With the dual-bank parameter clear, the bank 2 registers read 0, its output and output-enable pins stay 0, and its status and enable bits stay 0.
- R10: Only bit 31 of the global enable register and bits 1:0 of the enable register are stored. Their other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch1_pin_i | input | CH1_W | Bank 1 pin inputs |
| ch1_pin_o | output | CH1_W | Bank 1 output values |
| ch1_oe_o | output | CH1_W | Bank 1 output enables |
| ch2_pin_i | input | CH2_W | Bank 2 pin inputs |
| ch2_pin_o | output | CH2_W | Bank 2 output values |
| ch2_oe_o | output | CH2_W | Bank 2 output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The first set of stimuli steps bank 1 pins through a single transition. It separates synchronised read-back latency from the status latency, which is one edge later. A second pin change is then timed so that it lands in the same cycle as an acknowledging write, which shows whether detection outranks the toggle. A change on bank 2 alone shows that status bits are kept per bank. Software toggling of a status bit with different enable masks and global enable values shows whether the interrupt line really gates on both enables. A second instance built with a single bank receives the same bus traffic and pin changes, and shows that bank 2 stays inert.

// File: rtl/gpio_dual_chg.sv
module gpio_dual_chg #(
  parameter int          CH1_W        = 32,
  parameter int          CH2_W        = 32,
  parameter bit          DUAL         = 1'b1,
  parameter logic [31:0] CH1_DOUT_RST = 32'h0,
  parameter logic [31:0] CH1_DIR_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] CH2_DOUT_RST = 32'h0,
  parameter logic [31:0] CH2_DIR_RST  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CH1_W-1:0] ch1_pin_i,
  output logic [CH1_W-1:0] ch1_pin_o,
  output logic [CH1_W-1:0] ch1_oe_o,
  input  logic [CH2_W-1:0] ch2_pin_i,
  output logic [CH2_W-1:0] ch2_pin_o,
  output logic [CH2_W-1:0] ch2_oe_o,
  output logic             irq_o
);
  localparam logic [31:0] MSK1 = (CH1_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CH1_W) - 32'd1);
  localparam logic [31:0] MSK2 = !DUAL ? 32'h0 :
                                 (CH2_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CH2_W) - 32'd1);
  localparam logic [1:0]  BANKS = {DUAL, 1'b1};

  localparam logic [6:0] W_DAT1 = 7'h00;
  localparam logic [6:0] W_DIR1 = 7'h01;
  localparam logic [6:0] W_DAT2 = 7'h02;
  localparam logic [6:0] W_DIR2 = 7'h03;
  localparam logic [6:0] W_GIE  = 7'h47;
  localparam logic [6:0] W_STS  = 7'h48;
  localparam logic [6:0] W_IER  = 7'h4A;

  logic [31:0] dout1, dir1, dout2, dir2;
  logic [31:0] sa1, sb1, sc1, sa2, sb2, sc2;
  logic [1:0]  sts, ier, chg;
  logic        gie;

  wire       hit = (bus_addr[1:0] == 2'b00);
  wire [6:0] wa  = bus_addr[8:2];
  wire       wr  = bus_we && hit;

  assign chg = {|((sb2 ^ sc2) & MSK2), |((sb1 ^ sc1) & MSK1)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout1 <= CH1_DOUT_RST & MSK1;
      dir1  <= CH1_DIR_RST  & MSK1;
      dout2 <= CH2_DOUT_RST & MSK2;
      dir2  <= CH2_DIR_RST  & MSK2;
      {sa1, sb1, sc1, sa2, sb2, sc2} <= '0;
      sts <= '0;
      ier <= '0;
      gie <= 1'b0;
    end else begin
      sa1 <= 32'(ch1_pin_i) & MSK1;
      sb1 <= sa1;
      sc1 <= sb1;
      sa2 <= 32'(ch2_pin_i) & MSK2;
      sb2 <= sa2;
      sc2 <= sb2;
      sts <= (sts ^ ((wr && wa == W_STS) ? (bus_wdata[1:0] & BANKS) : 2'b00)) | chg;
      if (wr) begin
        case (wa)
          W_DAT1: dout1 <= bus_wdata & MSK1;
          W_DIR1: dir1  <= bus_wdata & MSK1;
          W_DAT2: dout2 <= bus_wdata & MSK2;
          W_DIR2: dir2  <= bus_wdata & MSK2;
          W_GIE:  gie   <= bus_wdata[31];
          W_IER:  ier   <= bus_wdata[1:0] & BANKS;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (wa)
        W_DAT1: bus_rdata = sb1;
        W_DIR1: bus_rdata = dir1;
        W_DAT2: bus_rdata = sb2;
        W_DIR2: bus_rdata = dir2;
        W_GIE:  bus_rdata = {gie, 31'b0};
        W_STS:  bus_rdata = {30'b0, sts};
        W_IER:  bus_rdata = {30'b0, ier};
        default: ;
      endcase
    end
  end

  assign ch1_pin_o = dout1[CH1_W-1:0];
  assign ch1_oe_o  = ~dir1[CH1_W-1:0];
  assign ch2_pin_o = dout2[CH2_W-1:0];
  assign ch2_oe_o  = (~dir2[CH2_W-1:0]) & MSK2[CH2_W-1:0];
  assign irq_o     = gie && |(sts & ier);
endmodule

// File: rtl/gpio_dual_chg_chk.sv
module gpio_dual_chg_chk #(
  parameter int          CH1_W       = 32,
  parameter int          CH2_W       = 32,
  parameter bit          DUAL        = 1'b1,
  parameter logic [31:0] CH1_DIR_RST = 32'hFFFF_FFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [8:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [CH1_W-1:0] ch1_pin_o,
  input logic [CH1_W-1:0] ch1_oe_o,
  input logic [CH2_W-1:0] ch2_pin_o,
  input logic [CH2_W-1:0] ch2_oe_o,
  input logic             irq_o
);
  // R3
  rst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ch1_oe_o == ~CH1_DIR_RST[CH1_W-1:0]);

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 9'h004) |=> ch1_oe_o == ~$past(bus_wdata[CH1_W-1:0]));

  // R2
  dout_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 9'h000) |=> ch1_pin_o == $past(bus_wdata[CH1_W-1:0]));

  // R7
  gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 9'h11C && !bus_wdata[31]) |=> !irq_o);

  // R8
  unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

  // R9
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !DUAL |-> (ch2_pin_o == '0 && ch2_oe_o == '0));
endmodule

bind gpio_dual_chg gpio_dual_chg_chk #(
  .CH1_W(CH1_W), .CH2_W(CH2_W), .DUAL(DUAL), .CH1_DIR_RST(CH1_DIR_RST)
) chk_i (.*);

// File: tb/gpio_dual_chg_tb_top.sv
module gpio_dual_chg_tb_top;
  localparam int          W1   = 8;
  localparam int          W2   = 12;
  localparam logic [31:0] M1   = 32'h0FF;
  localparam logic [31:0] M2   = 32'hFFF;
  localparam logic [31:0] D1R  = 32'h5A;
  localparam logic [31:0] T1R  = 32'hFFFF_FFFF;
  localparam logic [31:0] D2R  = 32'h0;
  localparam logic [31:0] T2R  = 32'hF0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [W1-1:0] p1 = '0;
  logic [W2-1:0] p2 = '0;
  logic [31:0] rdata, s_rdata;
  logic [W1-1:0] pin1_o, oe1_o, s_pin1_o, s_oe1_o;
  logic [W2-1:0] pin2_o, oe2_o, s_pin2_o, s_oe2_o;
  logic irq, s_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  gpio_dual_chg #(.CH1_W(W1), .CH2_W(W2), .DUAL(1'b1), .CH1_DOUT_RST(D1R),
    .CH1_DIR_RST(T1R), .CH2_DOUT_RST(D2R), .CH2_DIR_RST(T2R)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .ch1_pin_i(p1), .ch1_pin_o(pin1_o),
    .ch1_oe_o(oe1_o), .ch2_pin_i(p2), .ch2_pin_o(pin2_o), .ch2_oe_o(oe2_o), .irq_o(irq));

  gpio_dual_chg #(.CH1_W(W1), .CH2_W(W2), .DUAL(1'b0), .CH1_DOUT_RST(D1R),
    .CH1_DIR_RST(T1R), .CH2_DOUT_RST(D2R), .CH2_DIR_RST(T2R)) dut_single_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .ch1_pin_i(p1), .ch1_pin_o(s_pin1_o),
    .ch1_oe_o(s_oe1_o), .ch2_pin_i(p2), .ch2_pin_o(s_pin2_o), .ch2_oe_o(s_oe2_o), .irq_o(s_irq));

  // Behavioural reference for dut_i
  logic [31:0] m_d1, m_t1, m_d2, m_t2;
  logic [1:0]  m_sts, m_ier;
  logic        m_gie;
  logic [31:0] hq1[$];
  logic [31:0] hq2[$];

  always @(posedge clk) begin
    logic [1:0] c, tg;
    started <= 1'b1;
    if (!rst_n) begin
      m_d1 = D1R & M1; m_t1 = T1R & M1; m_d2 = D2R & M2; m_t2 = T2R & M2;
      m_sts = 0; m_ier = 0; m_gie = 0;
      hq1 = '{0, 0, 0};
      hq2 = '{0, 0, 0};
    end else begin
      c[0] = ((hq1[1] ^ hq1[2]) & M1) != 0;
      c[1] = ((hq2[1] ^ hq2[2]) & M2) != 0;
      tg = 2'b00;
      if (bus_we) begin
        case (bus_addr)
          9'h000: m_d1 = bus_wdata & M1;
          9'h004: m_t1 = bus_wdata & M1;
          9'h008: m_d2 = bus_wdata & M2;
          9'h00C: m_t2 = bus_wdata & M2;
          9'h11C: m_gie = bus_wdata[31];
          9'h120: tg = bus_wdata[1:0];
          9'h128: m_ier = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_sts = (m_sts ^ tg) | c;
      hq1.push_front(32'(p1)); void'(hq1.pop_back());
      hq2.push_front(32'(p2)); void'(hq2.pop_back());
    end
  end

  function automatic logic [31:0] mread(input logic [8:0] a);
    case (a)
      9'h000: return hq1[1];
      9'h004: return m_t1;
      9'h008: return hq2[1];
      9'h00C: return m_t2;
      9'h11C: return {m_gie, 31'b0};
      9'h120: return {30'b0, m_sts};
      9'h128: return {30'b0, m_ier};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(input logic [8:0] a);
    case (a)
      9'h000, 9'h008: return "R4";
      9'h004, 9'h00C: return "R1";
      9'h120: return "R5";
      9'h11C, 9'h128: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started) begin
      chk(rdata == mread(bus_addr), rtag(bus_addr), rdata, mread(bus_addr));
      chk(32'(pin1_o) == m_d1 && 32'(pin2_o) == m_d2, "R2", {pin2_o, 8'h0, pin1_o}, {m_d2[11:0], 8'h0, m_d1[7:0]});
      chk(32'(oe1_o) == (~m_t1 & M1) && 32'(oe2_o) == (~m_t2 & M2), "R2", {oe2_o, 8'h0, oe1_o}, 32'(~m_t1 & M1));
      chk(irq == (m_gie && (m_sts & m_ier) != 0), "R7", 32'(irq), 32'(m_gie && (m_sts & m_ier) != 0));
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    rd(9'h004, 32'hFF, "R3");
    rd(9'h00C, 32'hF0F, "R3");
    rd(9'h120, 32'h0, "R3");
    chk(pin1_o == 8'h5A && oe1_o == 8'h00, "R3", {oe1_o, pin1_o}, 32'h005A);
    // R2 direction and data
    wr(9'h004, 32'h0F);
    wr(9'h000, 32'hA5);
    #1 chk(oe1_o == 8'hF0, "R2", 32'(oe1_o), 32'hF0);
    chk(pin1_o == 8'hA5, "R2", 32'(pin1_o), 32'hA5);
    // R8 bits beyond width and unmapped offsets
    wr(9'h004, 32'hFFFF_FF3C);
    rd(9'h004, 32'h3C, "R8");
    wr(9'h014, 32'hFFFF_FFFF);
    rd(9'h014, 32'h0, "R8");
    rd(9'h006, 32'h0, "R8");
    rd(9'h004, 32'h3C, "R8");
    // R4 synchronizer latency, R5 status latency
    @(negedge clk);
    bus_addr = 9'h000; p1 = 8'h3C;
    @(negedge clk); #1 chk(rdata == 32'h0, "R4", rdata, 32'h0);
    @(negedge clk); #1 chk(rdata == 32'h3C, "R4", rdata, 32'h3C);
    bus_addr = 9'h120;
    #1 chk(rdata[0] == 1'b0, "R5", rdata, 32'h0);
    @(negedge clk); #1 chk(rdata == 32'h1, "R5", rdata, 32'h1);
    // R6 change in same cycle as clearing toggle
    @(negedge clk); p1 = 8'h3D;
    @(negedge clk);
    @(negedge clk); bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    #1 chk(rdata == 32'h1, "R6", rdata, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h0, "R6");
    wr(9'h120, 32'h2);
    rd(9'h120, 32'h2, "R6");
    chk(s_rdata == 32'h0, "R9", s_rdata, 32'h0);
    wr(9'h120, 32'h0);
    rd(9'h120, 32'h2, "R6");
    // R7 interrupt gating, R10 stored bits
    wr(9'h128, 32'h1);
    wr(9'h11C, 32'h8000_0000);
    #1 chk(irq == 1'b0, "R7", 32'(irq), 32'h0);
    wr(9'h128, 32'hFFFF_FFFF);
    #1 chk(irq == 1'b1, "R7", 32'(irq), 32'h1);
    rd(9'h128, 32'h3, "R10");
    chk(s_rdata == 32'h1, "R9", s_rdata, 32'h1);
    wr(9'h11C, 32'h7FFF_FFFF);
    #1 chk(irq == 1'b0, "R7", 32'(irq), 32'h0);
    wr(9'h11C, 32'hFFFF_FFFF);
    rd(9'h11C, 32'h8000_0000, "R10");
    wr(9'h120, 32'h2);
    rd(9'h120, 32'h0, "R6");
    // R5 bank 2 alone, R9 single-bank instance
    wr(9'h008, 32'hABC);
    wr(9'h00C, 32'h0);
    chk(pin2_o == 12'hABC && oe2_o == 12'hFFF, "R2", {oe2_o, 4'h0, pin2_o}, 32'hFFF0ABC);
    chk(s_pin2_o == '0 && s_oe2_o == '0, "R9", {s_oe2_o, 4'h0, s_pin2_o}, 32'h0);
    @(negedge clk); p2 = 12'h800;
    repeat (3) @(negedge clk);
    bus_addr = 9'h120;
    #1 chk(rdata == 32'h2, "R5", rdata, 32'h2);
    chk(s_rdata == 32'h0, "R9", s_rdata, 32'h0);
    rd(9'h008, 32'h800, "R4");
    chk(s_rdata == 32'h0, "R9", s_rdata, 32'h0);
    rd(9'h00C, 32'h0, "R1");
    chk(s_rdata == 32'h0, "R9", s_rdata, 32'h0);
    chk(irq == 1'b1, "R7", 32'(irq), 32'h1);
    chk(s_irq == 1'b0, "R9", 32'(s_irq), 32'h0);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule